// File: doc/BRIEF.md
# I2C Command Master with Deferred Read Acknowledge

This block is a command-driven master for a two-wire I2C bus. A host hands it one command at a time: generate a start condition, generate a stop condition, send a byte, receive a byte, or wait a number of microseconds. The bus lines are open drain. The block never drives a line high. It only asserts an output enable that pulls SCL or SDA low, and an external pull-up supplies every logic 1. The returning SDA level is read back through `sda_in`. The master does not support clock stretching. It has no SCL input and never waits on a slave.

The acknowledge of a received byte is not sent with the byte. After the eighth data bit the master stops with SCL low and SDA released, and raises `ack_pending`. The next accepted command settles that ninth bit. A start or a stop first clocks out a NACK. A read, a write or a delay first clocks out an ACK. Only then does the command itself run. A sent byte samples the slave's acknowledge on its ninth clock and reports the result.

Bus timing comes from a quarter-bit divider. `speed_sel` selects one of three quarter lengths, for bit rates near 50 kHz, 100 kHz and 400 kHz. The speed is captured when a command is accepted. A one-cycle `done` pulse ends every command, and `rd_data` and `ack_rx` are valid in that cycle.

Top module: `i2c_defer_master`

## Requirements
- R1: While reset is asserted and after it is released, `scl_oe` and `sda_oe` are 0 (both lines released), `cmd_ready` is 1, `done` is 0 and `ack_pending` is 0.
- R2: Each bus bit lasts four quarters. A quarter lasts Q_SLOW cycles for `speed_sel`=0, Q_STD for 1 and Q_FAST for 2 or 3. A write accepted with nothing pending gives `done` exactly 36·Q+1 cycles after the acceptance edge (counting the done cycle).
- R3: Command code 0 (start) runs four quarters: SCL keeps its previous state with SDA released, then SCL is released, then SDA is pulled low while SCL stays released. It ends with both lines pulled low. A start issued while SCL is low is a repeated start.
- R4: Command code 1 (stop) runs four quarters: SCL pulled low, then SDA pulled low, then SCL released, then SDA released. Both lines stay released afterwards.
- R5: Command code 2 (write) sends `cmd_data` MSB first as eight bits, then releases SDA for a ninth bit. Within a bit, SCL is low for quarters 0 and 3 and released for quarters 1 and 2. SDA changes only when SCL is low. `ack_rx` is 1 when `sda_in` is low at the end of quarter 1 of the ninth bit.
- R6: Command code 3 (read) clocks eight bits with SDA released. Each bit samples `sda_in` at the end of quarter 1, MSB first. It gives no ninth clock. In the done cycle `rd_data` holds the byte and `ack_pending` is 1.
- R7: If a start or stop is accepted while `ack_pending` is 1, one extra bit with SDA released (NACK) is clocked before the condition.
- R8: If a write, read or delay is accepted while `ack_pending` is 1, one extra bit with SDA pulled low (ACK) is clocked before the command.
- R9: `ack_pending` is 0 from the cycle after any command is accepted until a read ends.
- R10: Command code 4 (delay) with count N in 1..255 waits N·US_CYC cycles after any pending acknowledge bit, with both lines unchanged. `done` follows in the next cycle.
- R11: `cmd_ready` is 1 only when no command is running. `done` is a single-cycle pulse in the cycle after the last quarter. A `cmd_valid` raised while busy and dropped before the done cycle has no effect on the bus lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_sel | input | 2 | Bus rate select, captured at command acceptance |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Master idle and able to take a command |
| cmd_op | input | 3 | Command code: 0 start, 1 stop, 2 write, 3 read, 4 delay |
| cmd_data | input | 8 | Byte to send, or delay count in microseconds |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| done | output | 1 | One-cycle end-of-command pulse |
| rd_data | output | 8 | Last received byte |
| ack_rx | output | 1 | 1 when the last sent byte was acknowledged |
| ack_pending | output | 1 | A received byte awaits its acknowledge bit |

## Verification
Two things can fall in the same cycle: the done pulse of one command and the acceptance of the next, and that acceptance is also where the deferred acknowledge is decided. The bench provokes this by raising `cmd_valid` in the very cycle `done` appears, after reads followed by reads, writes, delays, starts and stops. A cycle-by-cycle model that tracks the line levels, the pending flag and the held line state predicts every cycle. The model checks that the ACK or NACK bit is inserted, that it has the correct SDA level, and that it comes before the new command's first quarter. The model also checks that a `cmd_valid` held during a busy read leaves the lines unchanged.

// File: rtl/i2c_defer_master.sv
module i2c_defer_master #(
  parameter int CLK_HZ = 200_000_000,
  parameter int Q_SLOW = CLK_HZ / 200_000,
  parameter int Q_STD  = CLK_HZ / 400_000,
  parameter int Q_FAST = CLK_HZ / 1_600_000,
  parameter int US_CYC = CLK_HZ / 1_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] speed_sel,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       ack_rx,
  output logic       ack_pending
);
  localparam int QMAX = (Q_SLOW > Q_STD) ? ((Q_SLOW > Q_FAST) ? Q_SLOW : Q_FAST)
                                         : ((Q_STD > Q_FAST) ? Q_STD : Q_FAST);
  localparam int QW = $clog2(QMAX + 1);
  localparam int UW = $clog2(US_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_ACK, S_START, S_STOP, S_WR, S_RD, S_DLY} st_t;

  st_t          st, nxt;
  logic [1:0]   ph;
  logic [QW-1:0] qcnt, qlim, qsel;
  logic [3:0]   bcnt;
  logic [7:0]   sh, dly_n, cnt_us;
  logic [UW-1:0] cnt_cyc;
  logic         ack_low, hold_scl, hold_sda;
  logic         tick, bit_end, seg_last, bit_low, is_cond;

  function automatic st_t op2st(input logic [2:0] op);
    case (op)
      3'd0:    return S_START;
      3'd1:    return S_STOP;
      3'd2:    return S_WR;
      3'd3:    return S_RD;
      default: return S_DLY;
    endcase
  endfunction

  assign qsel = (speed_sel == 2'd0) ? QW'(Q_SLOW) :
                (speed_sel == 2'd1) ? QW'(Q_STD)  : QW'(Q_FAST);
  assign is_cond   = (cmd_op == 3'd0) || (cmd_op == 3'd1);
  assign cmd_ready = (st == S_IDLE);
  assign tick      = (qcnt == qlim - 1'b1);
  assign bit_end   = tick && (ph == 2'd3);
  assign seg_last  = (st == S_WR) ? (bcnt == 4'd8) :
                     (st == S_RD) ? (bcnt == 4'd7) : 1'b1;
  assign bit_low   = (st == S_ACK) ? ack_low :
                     (st == S_WR)  ? ((bcnt != 4'd8) && !sh[7]) : 1'b0;

  always_comb begin
    scl_oe = hold_scl;
    sda_oe = hold_sda;
    case (st)
      S_ACK, S_WR, S_RD: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        sda_oe = bit_low;
      end
      S_START: begin
        scl_oe = (ph == 2'd0) ? hold_scl : 1'b0;
        sda_oe = ph[1];
      end
      S_STOP: begin
        scl_oe = !ph[1];
        sda_oe = (ph == 2'd0) ? hold_sda : (ph != 2'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  nxt <= S_IDLE;
      ph <= '0;      qcnt <= '0;  qlim <= '0;  bcnt <= '0;
      sh <= '0;      dly_n <= '0; cnt_us <= '0; cnt_cyc <= '0;
      ack_low <= 1'b0; hold_scl <= 1'b0; hold_sda <= 1'b0;
      done <= 1'b0;  rd_data <= '0; ack_rx <= 1'b0; ack_pending <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          qlim <= qsel;  qcnt <= '0;  ph <= '0;  bcnt <= '0;
          sh <= cmd_data;  dly_n <= cmd_data;
          cnt_us <= '0;  cnt_cyc <= '0;
          nxt <= op2st(cmd_op);
          ack_low <= !is_cond;
          ack_pending <= 1'b0;
          st <= ack_pending ? S_ACK : op2st(cmd_op);
        end
        S_DLY: begin
          if (cnt_cyc == UW'(US_CYC - 1)) begin
            cnt_cyc <= '0;
            if (cnt_us == dly_n - 8'd1) begin
              st <= S_IDLE;
              done <= 1'b1;
            end else cnt_us <= cnt_us + 8'd1;
          end else cnt_cyc <= cnt_cyc + 1'b1;
        end
        default: begin
          qcnt <= tick ? '0 : qcnt + 1'b1;
          if (tick) ph <= ph + 2'd1;
          if (tick && ph == 2'd1 && st == S_RD) sh <= {sh[6:0], sda_in};
          if (tick && ph == 2'd1 && st == S_WR && bcnt == 4'd8) ack_rx <= !sda_in;
          if (bit_end) begin
            bcnt <= bcnt + 4'd1;
            if (st == S_WR) sh <= {sh[6:0], 1'b0};
            if (seg_last) begin
              st <= S_IDLE;
              done <= 1'b1;
              case (st)
                S_ACK: begin
                  hold_scl <= 1'b1; hold_sda <= 1'b0;
                  st <= nxt; done <= 1'b0; bcnt <= '0;
                end
                S_START: begin hold_scl <= 1'b1; hold_sda <= 1'b1; end
                S_STOP:  begin hold_scl <= 1'b0; hold_sda <= 1'b0; end
                S_RD: begin
                  hold_scl <= 1'b1; hold_sda <= 1'b0;
                  rd_data <= sh; ack_pending <= 1'b1;
                end
                default: begin hold_scl <= 1'b1; hold_sda <= 1'b0; end
              endcase
            end
          end
        end
      endcase
    end
  end

  AST_SDA_MOVES_UNDER_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> (st == S_START || st == S_STOP)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !ack_pending); // R9
  AST_PEND_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_pending) |-> done); // R6
  AST_STOP_LEAVES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(st) == S_STOP) |-> (!scl_oe && !sda_oe)); // R4
  AST_START_LEAVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(st) == S_START) |-> (scl_oe && sda_oe)); // R3
endmodule

// File: tb/test_i2c_defer_master.sv
module test_i2c_defer_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] speed_sel = 2'd0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_data = 8'd0, rd_data;
  logic sda_in, scl_oe, sda_oe, done, ack_rx, ack_pending;
  logic slave_low = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_in = !(sda_oe || slave_low);

  i2c_defer_master #(.Q_SLOW(6), .Q_STD(4), .Q_FAST(3), .US_CYC(5)) i_i2c_defer_master (
    .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .rd_data(rd_data),
    .ack_rx(ack_rx), .ack_pending(ack_pending));

  typedef struct packed {
    logic scl, sda, slv, dn, pend;
    logic [3:0] req;
  } ent_t;

  ent_t expq[$];
  int checks = 0, fails = 0, pops = 0, exp_len = 0;
  string len_tag = "R2";
  bit m_hscl = 0, m_hsda = 0, m_pend = 0, noise = 0, finished = 0;
  bit chk_rd = 0, chk_ack = 0;
  logic [7:0] exp_rd = 0;
  logic exp_ack = 0;

  function automatic string rq(input logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic pushn(input bit scl, input bit sda, input bit slv, input logic [3:0] req, input int n);
    for (int k = 0; k < n; k++) expq.push_back('{scl, sda, slv, 1'b0, 1'b0, req});
  endtask

  task automatic push_bit(input int q, input bit low, input bit slv, input logic [3:0] req);
    pushn(1, low, slv, req, q);
    pushn(0, low, slv, req, 2 * q);
    pushn(1, low, slv, req, q);
  endtask

  task automatic build(input logic [2:0] op, input logic [7:0] d, input logic [1:0] spd,
                       input bit sack, input logic [7:0] sbyte);
    int q;
    q = (spd == 2'd0) ? 6 : (spd == 2'd1) ? 4 : 3;
    chk_rd = 0; chk_ack = 0;
    if (m_pend) begin
      // R7 NACK before start/stop, R8 ACK before others
      if (op == 3'd0 || op == 3'd1) push_bit(q, 0, 0, 4'd7);
      else push_bit(q, 1, 0, 4'd8);
      m_hscl = 1; m_hsda = 0; m_pend = 0;
    end
    case (op)
      3'd0: begin
        pushn(m_hscl, 0, 0, 4'd3, q); pushn(0, 0, 0, 4'd3, q);
        pushn(0, 1, 0, 4'd3, 2 * q);
        m_hscl = 1; m_hsda = 1;
      end
      3'd1: begin
        pushn(1, m_hsda, 0, 4'd4, q); pushn(1, 1, 0, 4'd4, q);
        pushn(0, 1, 0, 4'd4, q); pushn(0, 0, 0, 4'd4, q);
        m_hscl = 0; m_hsda = 0;
      end
      3'd2: begin
        for (int i = 7; i >= 0; i--) push_bit(q, !d[i], 0, 4'd5);
        push_bit(q, 0, sack, 4'd5);
        m_hscl = 1; m_hsda = 0;
        chk_ack = 1; exp_ack = sack;
      end
      3'd3: begin
        for (int i = 7; i >= 0; i--) push_bit(q, 0, !sbyte[i], 4'd6);
        m_hscl = 1; m_hsda = 0; m_pend = 1;
        chk_rd = 1; exp_rd = sbyte;
      end
      default: pushn(m_hscl, m_hsda, 0, 4'd10, d * 5);
    endcase
    expq.push_back('{m_hscl, m_hsda, 1'b0, 1'b1, m_pend, 4'd11});
  endtask

  task automatic eval();
    ent_t e;
    if (expq.size() != 0) begin
      e = expq.pop_front();
      pops++;
      chk(scl_oe == e.scl, rq(e.req), "scl_oe", scl_oe, e.scl);
      chk(sda_oe == e.sda, rq(e.req), "sda_oe", sda_oe, e.sda);
      chk(done == e.dn, "R11", "done", done, e.dn);
      chk(cmd_ready == e.dn, "R11", "cmd_ready", cmd_ready, e.dn);
      chk(ack_pending == e.pend, e.dn ? "R6" : "R9", "ack_pending", ack_pending, e.pend);
      if (e.dn) begin
        if (chk_rd) chk(rd_data == exp_rd, "R6", "rd_data", rd_data, exp_rd);
        if (chk_ack) chk(ack_rx == exp_ack, "R5", "ack_rx", ack_rx, exp_ack);
        if (exp_len != 0) chk(pops == exp_len, len_tag, "cycles to done", pops, exp_len);
      end
      slave_low = e.slv;
      if (noise) begin
        cmd_valid = (expq.size() != 0);
        cmd_op = 3'd1;
        if (expq.size() == 0) noise = 0;
      end
    end else begin
      chk(scl_oe == m_hscl && sda_oe == m_hsda, "R11", "idle lines", {scl_oe, sda_oe}, {m_hscl, m_hsda});
      chk(cmd_ready && !done, "R11", "idle ready/done", {cmd_ready, done}, 2);
      chk(ack_pending == m_pend, "R9", "idle ack_pending", ack_pending, m_pend);
    end
  endtask

  task automatic step();
    @(negedge clk);
    eval();
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] d, input logic [1:0] spd,
                         input bit sack, input logic [7:0] sbyte, input int len,
                         input string tag, input bit nz);
    while (expq.size() != 0) step();
    cmd_op = op; cmd_data = d; speed_sel = spd; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    build(op, d, spd, sack, sbyte);
    pops = 0; exp_len = len; len_tag = tag; noise = nz;
    eval();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && cmd_ready && !done && !ack_pending, "R1", "in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe && cmd_ready && !done && !ack_pending, "R1", "after reset", 0, 0);
    step(); step();
    run_cmd(3'd0, 8'h00, 2'd0, 0, 8'h00, 0, "R3", 0);
    run_cmd(3'd2, 8'hA5, 2'd0, 1, 8'h00, 36 * 6 + 1, "R2", 0);
    run_cmd(3'd2, 8'h3C, 2'd1, 0, 8'h00, 36 * 4 + 1, "R2", 0);
    run_cmd(3'd3, 8'h00, 2'd2, 0, 8'h96, 0, "R6", 0);
    run_cmd(3'd3, 8'h00, 2'd2, 0, 8'h5A, 0, "R8", 0);
    run_cmd(3'd4, 8'd3, 2'd2, 0, 8'h00, 4 * 3 + 3 * 5 + 1, "R10", 0);
    run_cmd(3'd3, 8'h00, 2'd1, 0, 8'hFF, 0, "R11", 1);
    run_cmd(3'd0, 8'h00, 2'd1, 0, 8'h00, 0, "R7", 0);
    run_cmd(3'd2, 8'h00, 2'd2, 1, 8'h00, 0, "R5", 0);
    run_cmd(3'd3, 8'h00, 2'd0, 0, 8'h01, 0, "R6", 0);
    run_cmd(3'd1, 8'h00, 2'd0, 0, 8'h00, 0, "R7", 0);
    run_cmd(3'd4, 8'd1, 2'd3, 0, 8'h00, 5 + 1, "R10", 0);
    run_cmd(3'd0, 8'h00, 2'd3, 0, 8'h00, 0, "R3", 0);
    run_cmd(3'd2, 8'hFF, 2'd3, 0, 8'h00, 36 * 3 + 1, "R2", 0);
    run_cmd(3'd1, 8'h00, 2'd3, 0, 8'h00, 0, "R4", 0);
    while (expq.size() != 0) step();
    repeat (4) step();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule